// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block holds the software-visible control state of a two-channel bus-master disk DMA controller. A host reaches it through a plain I/O slave port carrying an address, an access size, write data, a write strobe and combinational read data. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor-table pointer. A DMA engine next to the block reads the channel's run bit, direction and pointer, and it reports errors, interrupts and transfer completion back through single-cycle event inputs.

The status byte has three kinds of bits. Some are written straight by software. Some are cleared by writing a one and are set by hardware. The run bit can only be changed from the command register or by the engine. Within the command/status window only byte accesses take effect. Wider reads there return all ones across the access width, and spare offsets read as 0xFF.

Top module: `bmdma_regbank`

## Requirements
- R1: The bank spans 16 bytes and address bit 3 selects the channel (0 primary, 1 secondary). Inside a channel's 8 bytes, offset 0 is the command byte, offset 2 is the status byte, and offsets 4 to 7 hold the descriptor pointer. A write takes effect at the rising clock edge on which `wr_en` is high. `rd_data` is combinational and is zero above the access width.
- R2: `acc_size` encodes the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. At offsets 0 to 3, a wider read returns 0x0000FFFF for 2 bytes or 0xFFFFFFFF for 4 bytes, and a wider write changes nothing.
- R3: Offsets 1 and 3 read 0xFF on a byte read, and writes to them change nothing.
- R4: Writing the command byte with bit 0 = 1 sets status bit 0 (active); bit 0 = 0 clears it. Command bit 3 (direction) is stored, is read back at bit 3 and drives `dir_o`. Every other command bit reads 0. `active_o` mirrors status bit 0.
- R5: A status write loads bits 5 and 6 from the written byte and leaves bit 0 unchanged. Status bits 3, 4 and 7 always read 0.
- R6: In a status write, bits 1 (error) and 2 (interrupt) are cleared where the written byte holds a 1 and are kept where it holds a 0.
- R7: A high `hw_err[n]` sets status bit 1 and a high `hw_irq[n]` sets status bit 2 of channel n at the next edge. When a set and a write-one clear of the same bit fall on the same edge, the set wins.
- R8: A high `hw_done[n]` clears status bit 0 of channel n. A command write on the same edge decides the bit instead.
- R9: The pointer takes byte writes into any byte lane (lane = address bits 1:0, data in `wr_data[7:0]`), 2-byte writes into the lower or upper half (address bit 1, data in `wr_data[15:0]`), and 4-byte writes (data in `wr_data`, address bits 1:0 ignored). Reads use the same lane rules, shifted down to bit 0. Pointer bits 1:0 always read 0, on `rd_data` and on `desc_ptr_o` (channel n at bits 32n+31:32n).
- R10: Accesses and event inputs of one channel never change the other channel's registers.
- R11: Synchronous reset clears every command, status and pointer bit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Byte address in the bank |
| acc_size | input | 2 | Access width code |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data, right-aligned |
| hw_err | input | 2 | Per-channel error event |
| hw_irq | input | 2 | Per-channel interrupt event |
| hw_done | input | 2 | Per-channel transfer-finished event |
| active_o | output | 2 | Per-channel run bit |
| dir_o | output | 2 | Per-channel direction bit |
| desc_ptr_o | output | 64 | Per-channel descriptor pointer |

## Verification
The hardest cases to reach are same-edge collisions. A hardware error or interrupt event can meet a write-one clear of the same bit, and a transfer-finished event can meet a command write. Neither pairing comes up from separate port activity. The directed stimulus holds the event input during the very cycle in which the write strobe is high. A long random phase then drives writes and event inputs independently, which makes these collisions frequent, while a behavioural model is compared on every clock.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      RG_CMD = 2'd0,
      RG_STS = 2'd1,
      RG_PAD = 2'd2,
      RG_PTR = 2'd3
   } region_e;

   localparam int CMD_GO_BIT  = 0;
   localparam int CMD_DIR_BIT = 3;
   localparam int STS_ACT_BIT = 0;
   localparam int STS_ERR_BIT = 1;
   localparam int STS_IRQ_BIT = 2;
   localparam int STS_U5_BIT  = 5;
   localparam int STS_U6_BIT  = 6;

   localparam logic [7:0] PAD_READ = 8'hFF;

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CH_W   = 1,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          acc_size,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [CH_W-1:0]     ch_idx,
   output region_e             region,
   output logic                is_byte,
   output logic [DATA_W/8-1:0] lane_be,
   output logic [DATA_W-1:0]   lane_data,
   output logic [DATA_W-1:0]   width_mask,
   output logic [4:0]          rd_shift
);

   localparam int LANES = DATA_W / 8;

   logic [1:0] lane;

   assign ch_idx  = addr[ADDR_W-1 -: CH_W];
   assign is_byte = (acc_size_e'(acc_size) == SZ_BYTE);

   always_comb begin
      if (addr[2])
         region = RG_PTR;
      else if (addr[1:0] == 2'd0)
         region = RG_CMD;
      else if (addr[1:0] == 2'd2)
         region = RG_STS;
      else
         region = RG_PAD;
   end

   always_comb begin
      case (acc_size_e'(acc_size))
         SZ_BYTE: begin
            lane       = addr[1:0];
            width_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
            lane_be    = LANES'(1) << lane;
         end
         SZ_HALF: begin
            lane       = {addr[1], 1'b0};
            width_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            lane_be    = LANES'(3) << lane;
         end
         default: begin
            lane       = 2'd0;
            width_mask = {DATA_W{1'b1}};
            lane_be    = {LANES{1'b1}};
         end
      endcase
   end

   assign rd_shift  = {lane, 3'b000};
   assign lane_data = (wr_data & width_mask) << rd_shift;

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
#(
   parameter int PTR_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_we,
   input  logic               cmd_go,
   input  logic               cmd_dir,
   input  logic               sts_we,
   input  logic               sts_clr_err,
   input  logic               sts_clr_irq,
   input  logic               sts_u5,
   input  logic               sts_u6,
   input  logic [PTR_W/8-1:0] ptr_be,
   input  logic [PTR_W-1:0]   ptr_wdata,
   input  logic               ev_err,
   input  logic               ev_irq,
   input  logic               ev_done,
   output logic [7:0]         cmd_rd,
   output logic [7:0]         sts_rd,
   output logic [PTR_W-1:0]   ptr_rd,
   output logic               active,
   output logic               dir
);

   localparam int            PTR_BYTES = PTR_W / 8;
   localparam logic [PTR_W-1:0] PTR_KEEP = {{(PTR_W-2){1'b1}}, 2'b00};

   logic             act_q, dir_q, err_q, irq_q, u5_q, u6_q;
   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         dir_q <= 1'b0;
         err_q <= 1'b0;
         irq_q <= 1'b0;
         u5_q  <= 1'b0;
         u6_q  <= 1'b0;
         ptr_q <= '0;
      end else begin
         if (cmd_we) begin
            act_q <= cmd_go;
            dir_q <= cmd_dir;
         end else if (ev_done) begin
            act_q <= 1'b0;
         end
         if (sts_we) begin
            u5_q <= sts_u5;
            u6_q <= sts_u6;
         end
         err_q <= ev_err | (err_q & ~(sts_we & sts_clr_err));
         irq_q <= ev_irq | (irq_q & ~(sts_we & sts_clr_irq));
         for (int b = 0; b < PTR_BYTES; b++) begin
            if (ptr_be[b])
               ptr_q[b*8 +: 8] <= ptr_wdata[b*8 +: 8] & PTR_KEEP[b*8 +: 8];
         end
      end
   end

   always_comb begin
      cmd_rd              = '0;
      cmd_rd[CMD_DIR_BIT] = dir_q;
      sts_rd              = '0;
      sts_rd[STS_ACT_BIT] = act_q;
      sts_rd[STS_ERR_BIT] = err_q;
      sts_rd[STS_IRQ_BIT] = irq_q;
      sts_rd[STS_U5_BIT]  = u5_q;
      sts_rd[STS_U6_BIT]  = u6_q;
   end

   assign ptr_rd = ptr_q;
   assign active = act_q;
   assign dir    = dir_q;

   AST_GO_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      cmd_we && cmd_go |=> active); // R4
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ev_done && !cmd_we |=> !active); // R8
   AST_STS_KEEPS_ACT: assert property (@(posedge clk) disable iff (rst)
      sts_we && !cmd_we && !ev_done |=> active == $past(active)); // R5
   AST_W1C_ERR: assert property (@(posedge clk) disable iff (rst)
      sts_we && sts_clr_err && !ev_err |=> !sts_rd[STS_ERR_BIT]); // R6
   AST_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
      ev_err |=> sts_rd[STS_ERR_BIT]); // R7
   AST_IRQ_WINS: assert property (@(posedge clk) disable iff (rst)
      ev_irq |=> sts_rd[STS_IRQ_BIT]); // R7

endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
   import bmdma_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int DATA_W    = 32,
   parameter int WIN_BYTES = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [3:0]               addr,
   input  logic [1:0]               acc_size,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_CH-1:0]        hw_err,
   input  logic [NUM_CH-1:0]        hw_irq,
   input  logic [NUM_CH-1:0]        hw_done,
   output logic [NUM_CH-1:0]        active_o,
   output logic [NUM_CH-1:0]        dir_o,
   output logic [NUM_CH*DATA_W-1:0] desc_ptr_o
);

   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int ADDR_W = CH_W + $clog2(WIN_BYTES);
   localparam int LANES  = DATA_W / 8;

   if (NUM_CH != 2 || DATA_W != 32 || WIN_BYTES != 8 || ADDR_W != 4) begin : g_bad_cfg
      $error("bmdma_regbank: only two channels, 32-bit data and 8-byte windows are supported");
   end

   logic [CH_W-1:0]   ch_idx;
   region_e           region;
   logic              is_byte;
   logic [LANES-1:0]  lane_be;
   logic [DATA_W-1:0] lane_data;
   logic [DATA_W-1:0] width_mask;
   logic [4:0]        rd_shift;

   bmdma_decode #(
      .ADDR_W (ADDR_W),
      .CH_W   (CH_W),
      .DATA_W (DATA_W)
   ) u_decode (
      .addr       (addr),
      .acc_size   (acc_size),
      .wr_data    (wr_data),
      .ch_idx     (ch_idx),
      .region     (region),
      .is_byte    (is_byte),
      .lane_be    (lane_be),
      .lane_data  (lane_data),
      .width_mask (width_mask),
      .rd_shift   (rd_shift)
   );

   logic [7:0]        cmd_rd [NUM_CH];
   logic [7:0]        sts_rd [NUM_CH];
   logic [DATA_W-1:0] ptr_rd [NUM_CH];
   logic [NUM_CH-1:0] cmd_we, sts_we;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic             sel;
      logic [LANES-1:0] ptr_be;

      assign sel       = wr_en && (ch_idx == CH_W'(i));
      assign cmd_we[i] = sel && is_byte && (region == RG_CMD);
      assign sts_we[i] = sel && is_byte && (region == RG_STS);
      assign ptr_be    = (sel && (region == RG_PTR)) ? lane_be : '0;

      bmdma_chan #(
         .PTR_W (DATA_W)
      ) u_chan (
         .clk         (clk),
         .rst         (rst),
         .cmd_we      (cmd_we[i]),
         .cmd_go      (wr_data[CMD_GO_BIT]),
         .cmd_dir     (wr_data[CMD_DIR_BIT]),
         .sts_we      (sts_we[i]),
         .sts_clr_err (wr_data[STS_ERR_BIT]),
         .sts_clr_irq (wr_data[STS_IRQ_BIT]),
         .sts_u5      (wr_data[STS_U5_BIT]),
         .sts_u6      (wr_data[STS_U6_BIT]),
         .ptr_be      (ptr_be),
         .ptr_wdata   (lane_data),
         .ev_err      (hw_err[i]),
         .ev_irq      (hw_irq[i]),
         .ev_done     (hw_done[i]),
         .cmd_rd      (cmd_rd[i]),
         .sts_rd      (sts_rd[i]),
         .ptr_rd      (ptr_rd[i]),
         .active      (active_o[i]),
         .dir         (dir_o[i])
      );

      assign desc_ptr_o[i*DATA_W +: DATA_W] = ptr_rd[i];
   end

   always_comb begin
      if (region == RG_PTR)
         rd_data = (ptr_rd[ch_idx] >> rd_shift) & width_mask;
      else if (!is_byte)
         rd_data = width_mask;
      else begin
         case (region)
            RG_CMD:  rd_data = {{(DATA_W-8){1'b0}}, cmd_rd[ch_idx]};
            RG_STS:  rd_data = {{(DATA_W-8){1'b0}}, sts_rd[ch_idx]};
            default: rd_data = {{(DATA_W-8){1'b0}}, PAD_READ};
         endcase
      end
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cmd_we, sts_we})); // R10
   AST_WIDE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
      wr_en && !addr[2] && acc_size != 2'd0 && hw_done == '0 |=> $stable(active_o) && $stable(dir_o)); // R2

endmodule

// File: tb/tb_bmdma_regbank.sv
module tb_bmdma_regbank;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  addr = '0;
   logic [1:0]  acc_size = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  hw_err = '0, hw_irq = '0, hw_done = '0;
   logic [1:0]  active_o, dir_o;
   logic [63:0] desc_ptr_o;

   int checks = 0;
   int errors = 0;

   bmdma_regbank dut (
      .clk        (clk),
      .rst        (rst),
      .addr       (addr),
      .acc_size   (acc_size),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .hw_err     (hw_err),
      .hw_irq     (hw_irq),
      .hw_done    (hw_done),
      .active_o   (active_o),
      .dir_o      (dir_o),
      .desc_ptr_o (desc_ptr_o)
   );

   always #5 clk = ~clk;

   // behavioural reference state
   bit          m_act [2];
   bit          m_dir [2];
   bit          m_err [2];
   bit          m_irq [2];
   bit          m_u5  [2];
   bit          m_u6  [2];
   logic [31:0] m_ptr [2];

   function automatic int width_bytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] ones_of(input int nb);
      return (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (nb * 8)) - 32'd1);
   endfunction

   function automatic logic [31:0] model_read(input logic [3:0] a, input logic [1:0] s);
      int          c, nb, lane;
      logic [31:0] v;
      c  = a[3];
      nb = width_bytes(s);
      if (a[2]) begin
         lane = (nb == 1) ? a[1:0] : (nb == 2) ? a[1] * 2 : 0;
         v = m_ptr[c] & 32'hFFFF_FFFC;
         return (v >> (lane * 8)) & ones_of(nb);
      end
      if (nb != 1) return ones_of(nb);
      case (a[1:0])
         2'd0: return {28'd0, m_dir[c], 3'b000};
         2'd2: return {25'd0, m_u6[c], m_u5[c], 2'b00, m_irq[c], m_err[c], m_act[c]};
         default: return 32'h0000_00FF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < 2; c++) begin
            m_act[c] = 0; m_dir[c] = 0; m_err[c] = 0; m_irq[c] = 0;
            m_u5[c] = 0; m_u6[c] = 0; m_ptr[c] = 0;
         end
      end else begin
         bit cw [2];
         bit cgo [2];
         bit sw [2];
         int c, nb, lane;
         for (int k = 0; k < 2; k++) begin cw[k] = 0; cgo[k] = 0; sw[k] = 0; end
         c  = addr[3];
         nb = width_bytes(acc_size);
         if (wr_en) begin
            if (addr[2]) begin
               lane = (nb == 1) ? addr[1:0] : (nb == 2) ? addr[1] * 2 : 0;
               for (int b = 0; b < nb; b++)
                  m_ptr[c][(lane + b) * 8 +: 8] = wr_data[b * 8 +: 8];
            end else if (nb == 1 && addr[1:0] == 2'd0) begin
               cw[c] = 1; cgo[c] = wr_data[0]; m_dir[c] = wr_data[3];
            end else if (nb == 1 && addr[1:0] == 2'd2) begin
               sw[c] = 1; m_u5[c] = wr_data[5]; m_u6[c] = wr_data[6];
            end
         end
         for (int k = 0; k < 2; k++) begin
            if (sw[k] && (k == c) && wr_data[1]) m_err[k] = 0;
            if (sw[k] && (k == c) && wr_data[2]) m_irq[k] = 0;
            if (hw_err[k]) m_err[k] = 1;
            if (hw_irq[k]) m_irq[k] = 1;
            if (cw[k]) m_act[k] = cgo[k];
            else if (hw_done[k]) m_act[k] = 0;
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the reference model
   always @(negedge clk) begin
      if (!rst) begin
         chk(rd_data, model_read(addr, acc_size), "R1 R2 R3 R9 read port vs model");
         chk({30'd0, active_o}, {30'd0, m_act[1], m_act[0]}, "R4 R8 R10 active_o vs model");
         chk({30'd0, dir_o}, {30'd0, m_dir[1], m_dir[0]}, "R4 R10 dir_o vs model");
         chk(desc_ptr_o[31:0], m_ptr[0] & 32'hFFFF_FFFC, "R9 desc_ptr ch0 vs model");
         chk(desc_ptr_o[63:32], m_ptr[1] & 32'hFFFF_FFFC, "R9 R10 desc_ptr ch1 vs model");
      end
   end

   task automatic wr_ev(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d,
                        input logic [1:0] e, input logic [1:0] q, input logic [1:0] f);
      @(posedge clk); #2;
      addr = a; acc_size = s; wr_data = d; wr_en = 1'b1;
      hw_err = e; hw_irq = q; hw_done = f;
      @(posedge clk); #2;
      wr_en = 1'b0; hw_err = '0; hw_irq = '0; hw_done = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
      wr_ev(a, s, d, 2'b00, 2'b00, 2'b00);
   endtask

   task automatic ev(input logic [1:0] e, input logic [1:0] q, input logic [1:0] f);
      @(posedge clk); #2;
      hw_err = e; hw_irq = q; hw_done = f;
      @(posedge clk); #2;
      hw_err = '0; hw_irq = '0; hw_done = '0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp, input string tag);
      @(posedge clk); #2;
      addr = a; acc_size = s; wr_en = 1'b0;
      #2;
      chk(rd_data, exp, tag);
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;

      // R11 reset state
      rd(4'h0, 2'd0, 32'h00, "R11 cmd after reset");
      rd(4'h2, 2'd0, 32'h00, "R11 status after reset");
      rd(4'h4, 2'd2, 32'h0,  "R11 pointer after reset");

      // R4 command
      wr(4'h0, 2'd0, 32'hFF);
      rd(4'h0, 2'd0, 32'h08, "R4 cmd reads only dir");
      rd(4'h2, 2'd0, 32'h01, "R4 go sets active");
      chk({30'd0, active_o, dir_o}, 32'h5, "R4 active_o/dir_o ch0");

      // R2 wide accesses
      rd(4'h0, 2'd1, 32'h0000_FFFF, "R2 half read all ones");
      rd(4'h2, 2'd2, 32'hFFFF_FFFF, "R2 word read all ones");
      wr(4'h0, 2'd2, 32'h0);
      wr(4'h2, 2'd1, 32'h0000_FF00);
      rd(4'h0, 2'd0, 32'h08, "R2 wide write ignored cmd");
      rd(4'h2, 2'd0, 32'h01, "R2 wide write ignored status");

      // R3 spare offsets
      wr(4'h1, 2'd0, 32'h00);
      wr(4'h3, 2'd0, 32'hFF);
      rd(4'h1, 2'd0, 32'hFF, "R3 offset 1 reads FF");
      rd(4'h3, 2'd0, 32'hFF, "R3 offset 3 reads FF");
      rd(4'h2, 2'd0, 32'h01, "R3 spare writes no effect");

      // R5 status write
      wr(4'h2, 2'd0, 32'hFE);
      rd(4'h2, 2'd0, 32'h61, "R5 bits5/6 written, bit0 kept, 3/4/7 zero");

      // R7 hardware set, then collision with clear
      ev(2'b01, 2'b01, 2'b00);
      rd(4'h2, 2'd0, 32'h67, "R7 err/irq set by hardware");
      wr_ev(4'h2, 2'd0, 32'h66, 2'b01, 2'b00, 2'b00);
      rd(4'h2, 2'd0, 32'h63, "R7 set beats clear, irq cleared");

      // R6 write-one-to-clear
      wr(4'h2, 2'd0, 32'h60);
      rd(4'h2, 2'd0, 32'h63, "R6 zeros keep bits 1/2");
      wr(4'h2, 2'd0, 32'h62);
      rd(4'h2, 2'd0, 32'h61, "R6 one clears error");

      // R8 done and collision with command write
      ev(2'b00, 2'b00, 2'b01);
      rd(4'h2, 2'd0, 32'h60, "R8 done clears active");
      wr_ev(4'h0, 2'd0, 32'h01, 2'b00, 2'b00, 2'b01);
      rd(4'h2, 2'd0, 32'h61, "R8 command beats done");
      rd(4'h0, 2'd0, 32'h00, "R4 dir rewritten to 0");

      // R10 isolation
      rd(4'hA, 2'd0, 32'h00, "R10 ch1 status untouched");
      wr(4'h8, 2'd0, 32'h09);
      ev(2'b10, 2'b10, 2'b00);
      rd(4'hA, 2'd0, 32'h07, "R10 ch1 own state");
      rd(4'h2, 2'd0, 32'h61, "R10 ch0 unaffected by ch1");

      // R9 pointer lanes
      wr(4'h4, 2'd2, 32'hDEAD_BEEF);
      rd(4'h4, 2'd2, 32'hDEAD_BEEC, "R9 word write, low bits zero");
      wr(4'h7, 2'd0, 32'h12);
      rd(4'h4, 2'd2, 32'h12AD_BEEC, "R9 byte lane 3 write");
      rd(4'h6, 2'd1, 32'h0000_12AD, "R9 upper half read");
      rd(4'h4, 2'd0, 32'h0000_00EC, "R9 byte lane 0 read");
      wr(4'h4, 2'd1, 32'h0000_5677);
      rd(4'h4, 2'd2, 32'h12AD_5674, "R9 lower half write");
      chk(desc_ptr_o[31:0], 32'h12AD_5674, "R9 desc_ptr_o ch0");
      rd(4'hC, 2'd2, 32'h0, "R10 ch1 pointer untouched");

      // random phase, model compared every clock
      for (int n = 0; n < 4000; n++) begin
         @(posedge clk); #2;
         addr     = 4'($urandom);
         acc_size = 2'($urandom);
         wr_en    = ($urandom % 3) == 0;
         wr_data  = $urandom;
         for (int k = 0; k < 2; k++) begin
            hw_err[k]  = ($urandom % 6) == 0;
            hw_irq[k]  = ($urandom % 6) == 0;
            hw_done[k] = ($urandom % 8) == 0;
         end
      end
      @(posedge clk); #2;
      wr_en = 1'b0; hw_err = '0; hw_irq = '0; hw_done = '0;

      // R11 reset clears everything again
      wr(4'h8, 2'd0, 32'h09);
      wr(4'hC, 2'd2, 32'hFFFF_FFFF);
      @(posedge clk); #2 rst = 1'b1;
      @(posedge clk); #2 rst = 1'b0;
      rd(4'hA, 2'd0, 32'h00, "R11 ch1 status cleared");
      rd(4'hC, 2'd2, 32'h0,  "R11 ch1 pointer cleared");
      rd(4'h8, 2'd0, 32'h00, "R11 ch1 cmd cleared");
      chk({30'd0, active_o}, 32'h0, "R11 active_o cleared");

      repeat (2) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule